// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Controller

This block is the card-side controller that a host uses to find and configure a plug-and-play expansion card. The host sends commands through two ports. The address port selects a card-level register index. The write-data port writes to the selected register. Reads come back through a relocatable read port. The controller holds the card's protocol state and its 8-bit card select number (CSN). It also holds the currently selected logical device, and it feeds out a fixed stream of resource bytes, with a ready flag the host polls.

The card starts in the locked state and waits there for an unlock key. This key is reduced to a single input pulse. A wake command addressed to a CSN moves a sleeping card on: to the isolation state when the wake byte is zero, or to the configuration state otherwise. The control register has three bits that act independently and are not stored:

- one resets the logical-device settings;
- one drops the card back to the locked state;
- one clears the CSN.

Top module: `pnp_card_ctrl`

## Requirements
- R1: After reset, cardState is 0 (locked), and csn, ldn, readPortAddr and devReset are all 0. State codes are: 0 locked, 1 sleep, 2 isolation, 3 configuration.
- R2: While locked, a keyOk pulse moves cardState to 1 on the next cycle. Every write-data port write made while locked is ignored.
- R3: A write to index 0x00, in any unlocked state, sets readPortAddr to {data, 2'b00}. This index reads back as 0.
- R4: A write to index 0x02 with bit 0 set, in any unlocked state, raises devReset for exactly one cycle after the write. cardState and csn are left unchanged.
- R5: A write to index 0x02 with bit 1 set, in any unlocked state, returns cardState to 0. csn and ldn are kept.
- R6: A write to index 0x02 with bit 2 set, in any unlocked state, clears csn to 0. Index 0x02 always reads back as 0.
- R7: A write to index 0x03 (wake) changes state only for a card in state 1 whose csn equals the data byte. The card goes to 2 if the byte is 0, and to 3 otherwise. A wake that does not match leaves the state as it is.
- R8: Any wake write made while unlocked rewinds the resource stream to its first byte, and the stream is ready on the following cycle.
- R9: In state 3, index 0x05 reads {7'b0, ready}. Reading index 0x04 while ready returns resource byte k = (60 + 29*k) mod 256 and advances k. Ready is 0 for the one cycle after each byte is read, then 1 again. After 6 bytes it stays 0, and index 0x04 then reads 0.
- R10: csn (index 0x06) is writable in states 2 and 3. ldn (index 0x07) is writable only in state 3. Both read back at their own index.
- R11: Outside state 3, rdData is 0 for every index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| keyOk | input | 1 | One-cycle pulse: unlock key recognised |
| addrWe | input | 1 | Write to the address port (index = wrData) |
| dataWe | input | 1 | Write to the write-data port at the current index |
| dataRe | input | 1 | Read through the read port at the current index |
| wrData | input | 8 | Write data for both ports |
| rdData | output | 8 | Read-port data for the current index (combinational) |
| cardState | output | 2 | Protocol state code |
| csn | output | 8 | Card select number |
| ldn | output | 8 | Selected logical device number |
| readPortAddr | output | 10 | Programmed read-port I/O address |
| devReset | output | 1 | One-cycle pulse resetting logical-device settings |

## Verification
Two cases are provoked on purpose. In the first, a resource read and a wake rewind fall on adjacent edges. The host reads a byte while moving the index to the wake register in the same cycle. The wake write then lands in the cycle where ready is low after that read. The check is that the rewind wins: ready returns the next cycle, and the first byte is offered again. In the second, a single control write sets all three control bits. In the same cycle, the CSN clears, the state falls to locked and the device reset pulses, while ldn is kept. A behavioural reference model is compared with every output on every clock, and directed checks mark each step.

// File: rtl/pnp_card_pkg.sv
package pnp_card_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    ST_LOCKED  = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_ISOLATE = 2'd2,
    ST_CONFIG  = 2'd3
  } cardState_e;

  localparam logic [DW-1:0] IDX_RDPORT = 8'h00;
  localparam logic [DW-1:0] IDX_CTRL   = 8'h02;
  localparam logic [DW-1:0] IDX_WAKE   = 8'h03;
  localparam logic [DW-1:0] IDX_RES    = 8'h04;
  localparam logic [DW-1:0] IDX_STAT   = 8'h05;
  localparam logic [DW-1:0] IDX_CSN    = 8'h06;
  localparam logic [DW-1:0] IDX_LDN    = 8'h07;

  // control-bit positions inside the control register
  localparam int CB_DEVRST = 0;
  localparam int CB_LOCK   = 1;
  localparam int CB_CSNCLR = 2;

  typedef struct packed {
    logic setRdPort;
    logic setCsn;
    logic clrCsn;
    logic setLdn;
    logic devDflt;
    logic resNext;
    logic resRewind;
  } dpStrobe_t;
endpackage

// File: rtl/pnp_card_fsm.sv
module pnp_card_fsm
  import pnp_card_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          keyOk,
  input  logic          addrWe,
  input  logic          dataWe,
  input  logic          dataRe,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] csnQ,
  output cardState_e    stateQ,
  output logic [DW-1:0] idxQ,
  output dpStrobe_t     strb
);
  cardState_e stateD;
  logic wrOk;
  logic hitCtrl;
  logic hitWake;

  assign wrOk    = dataWe && (stateQ != ST_LOCKED);
  assign hitCtrl = wrOk && (idxQ == IDX_CTRL);
  assign hitWake = wrOk && (idxQ == IDX_WAKE);

  always_comb begin
    strb           = '0;
    strb.setRdPort = wrOk && (idxQ == IDX_RDPORT);
    strb.devDflt   = hitCtrl && wrData[CB_DEVRST];
    strb.clrCsn    = hitCtrl && wrData[CB_CSNCLR];
    strb.setCsn    = wrOk && (idxQ == IDX_CSN) &&
                     (stateQ == ST_ISOLATE || stateQ == ST_CONFIG);
    strb.setLdn    = wrOk && (idxQ == IDX_LDN) && (stateQ == ST_CONFIG);
    strb.resRewind = hitWake;
    strb.resNext   = dataRe && (stateQ == ST_CONFIG) && (idxQ == IDX_RES);
  end

  always_comb begin
    stateD = stateQ;
    if (stateQ == ST_LOCKED && keyOk) begin
      stateD = ST_SLEEP;
    end else if (hitCtrl && wrData[CB_LOCK]) begin
      stateD = ST_LOCKED;
    end else if (hitWake && stateQ == ST_SLEEP && wrData == csnQ) begin
      stateD = (wrData == '0) ? ST_ISOLATE : ST_CONFIG;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_LOCKED;
      idxQ   <= '0;
    end else begin
      stateQ <= stateD;
      if (addrWe) idxQ <= wrData;
    end
  end
endmodule

// File: rtl/pnp_card_dp.sv
module pnp_card_dp
  import pnp_card_pkg::*;
#(
  parameter int RES_LEN  = 6,
  parameter int ROM_SEED = 60,
  parameter int ROM_STEP = 29,
  parameter int PORT_LSB = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strb,
  input  cardState_e             stateQ,
  input  logic [DW-1:0]          idxQ,
  input  logic [DW-1:0]          wrData,
  output logic [DW-1:0]          csnQ,
  output logic [DW-1:0]          ldnQ,
  output logic [DW+PORT_LSB-1:0] rdPortQ,
  output logic                   devRstQ,
  output logic                   resReady,
  output logic [DW-1:0]          rdData
);
  localparam int PW = $clog2(RES_LEN + 1);
  localparam logic [PW-1:0] PTR_END = PW'(RES_LEN);

  logic [PW-1:0] ptrQ;
  logic          busyQ;
  logic [DW-1:0] romByte;

  assign resReady = !busyQ && (ptrQ < PTR_END);
  assign romByte  = DW'(32'(ROM_SEED) + 32'(ROM_STEP) * 32'(ptrQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csnQ    <= '0;
      ldnQ    <= '0;
      rdPortQ <= '0;
      devRstQ <= 1'b0;
      ptrQ    <= '0;
      busyQ   <= 1'b0;
    end else begin
      devRstQ <= strb.devDflt;
      if (strb.clrCsn)      csnQ <= '0;
      else if (strb.setCsn) csnQ <= wrData;
      if (strb.setLdn)      ldnQ <= wrData;
      if (strb.setRdPort)   rdPortQ <= {wrData, {PORT_LSB{1'b0}}};
      if (strb.resRewind) begin
        ptrQ  <= '0;
        busyQ <= 1'b0;
      end else if (strb.resNext && resReady) begin
        ptrQ  <= ptrQ + 1'b1;
        busyQ <= 1'b1;
      end else begin
        busyQ <= 1'b0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (stateQ == ST_CONFIG) begin
      unique case (idxQ)
        IDX_RES:  rdData = resReady ? romByte : '0;
        IDX_STAT: rdData = {{(DW-1){1'b0}}, resReady};
        IDX_CSN:  rdData = csnQ;
        IDX_LDN:  rdData = ldnQ;
        default:  rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/pnp_card_ctrl.sv
module pnp_card_ctrl
  import pnp_card_pkg::*;
#(
  parameter int RES_LEN  = 6,
  parameter int ROM_SEED = 60,
  parameter int ROM_STEP = 29,
  parameter int PORT_LSB = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        keyOk,
  input  logic        addrWe,
  input  logic        dataWe,
  input  logic        dataRe,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic [1:0]  cardState,
  output logic [7:0]  csn,
  output logic [7:0]  ldn,
  output logic [9:0]  readPortAddr,
  output logic        devReset
);
  cardState_e    stateQ;
  logic [DW-1:0] idxQ;
  dpStrobe_t     strb;
  logic          resReady;

  pnp_card_fsm u_ctrl (
    .clk(clk), .rstN(rstN), .keyOk(keyOk), .addrWe(addrWe),
    .dataWe(dataWe), .dataRe(dataRe), .wrData(wrData), .csnQ(csn),
    .stateQ(stateQ), .idxQ(idxQ), .strb(strb)
  );

  pnp_card_dp #(
    .RES_LEN(RES_LEN), .ROM_SEED(ROM_SEED),
    .ROM_STEP(ROM_STEP), .PORT_LSB(PORT_LSB)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stateQ(stateQ), .idxQ(idxQ),
    .wrData(wrData), .csnQ(csn), .ldnQ(ldn), .rdPortQ(readPortAddr),
    .devRstQ(devReset), .resReady(resReady), .rdData(rdData)
  );

  assign cardState = stateQ;
endmodule

// File: rtl/pnp_card_ctrl_chk.sv
module pnp_card_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       keyOk,
  input logic       dataWe,
  input logic       dataRe,
  input logic [7:0] wrData,
  input logic [1:0] cardState,
  input logic [7:0] csn,
  input logic [7:0] ldn,
  input logic       devReset,
  input logic [7:0] idx,
  input logic       ready
);
  // R2
  key_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cardState == 2'd0 && keyOk) |=> (cardState == 2'd1));

  // R2
  locked_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cardState == 2'd0) |=> (cardState == 2'd0 || cardState == 2'd1));

  // R4
  dev_reset_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    devReset |-> $past(dataWe && wrData[0] && idx == 8'h02 && cardState != 2'd0));

  // R7
  wake_config_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cardState) == 2'd1 && cardState == 2'd3) |-> ($past(csn) != 8'd0));

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cardState == 2'd3 && dataRe && idx == 8'h04 && ready && !dataWe) |=> !ready);

  // R10
  ldn_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cardState != 2'd3) |=> $stable(ldn));
endmodule

bind pnp_card_ctrl pnp_card_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .keyOk(keyOk), .dataWe(dataWe), .dataRe(dataRe),
  .wrData(wrData), .cardState(cardState), .csn(csn), .ldn(ldn),
  .devReset(devReset), .idx(u_ctrl.idxQ), .ready(u_dp.resReady)
);

// File: tb/pnp_card_ctrl_tb_top.sv
`timescale 1ns/1ps
module pnp_card_ctrl_tb_top;
  localparam int LEN = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic keyOk = 1'b0, addrWe = 1'b0, dataWe = 1'b0, dataRe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData, csn, ldn;
  logic [1:0] cardState;
  logic [9:0] readPortAddr;
  logic devReset;

  int total = 0;
  int bad = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pnp_card_ctrl dut_i (
    .clk(clk), .rstN(rstN), .keyOk(keyOk), .addrWe(addrWe), .dataWe(dataWe),
    .dataRe(dataRe), .wrData(wrData), .rdData(rdData), .cardState(cardState),
    .csn(csn), .ldn(ldn), .readPortAddr(readPortAddr), .devReset(devReset)
  );

  // behavioural reference model
  int mState = 0, mCsn = 0, mLdn = 0, mPort = 0, mIdx = 0, mPtr = 0;
  bit mBusy = 0, mDev = 0;

  function automatic int resByte(int k);
    return (60 + 29 * k) % 256;
  endfunction

  function automatic bit mReady();
    return !mBusy && (mPtr < LEN);
  endfunction

  function automatic int mRead();
    if (mState != 3) return 0;
    case (mIdx)
      4: return mReady() ? resByte(mPtr) : 0;
      5: return mReady() ? 1 : 0;
      6: return mCsn;
      7: return mLdn;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCsn = 0; mLdn = 0; mPort = 0; mIdx = 0;
      mPtr = 0; mBusy = 0; mDev = 0;
    end else begin
      int d;
      bit wr, nxtBusy;
      int nState, nCsn, nLdn, nPort, nIdx, nPtr;
      d = int'(wrData);
      wr = dataWe && (mState != 0);
      nState = mState; nCsn = mCsn; nLdn = mLdn; nPort = mPort;
      nIdx = addrWe ? d : mIdx;
      nPtr = mPtr; nxtBusy = 0;
      mDev = wr && mIdx == 2 && d[0];
      if (wr && mIdx == 0) nPort = d * 4;
      if (wr && mIdx == 2 && d[2]) nCsn = 0;
      if (wr && mIdx == 6 && (mState == 2 || mState == 3)) nCsn = d;
      if (wr && mIdx == 7 && mState == 3) nLdn = d;
      if (mState == 0 && keyOk) nState = 1;
      else if (wr && mIdx == 2 && d[1]) nState = 0;
      else if (wr && mIdx == 3 && mState == 1 && d == mCsn) nState = (d == 0) ? 2 : 3;
      if (wr && mIdx == 3) nPtr = 0;
      else if (dataRe && mState == 3 && mIdx == 4 && mReady()) begin
        nPtr = mPtr + 1; nxtBusy = 1;
      end
      mState = nState; mCsn = nCsn; mLdn = nLdn; mPort = nPort;
      mIdx = nIdx; mPtr = nPtr; mBusy = nxtBusy;
    end
  end

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // compare every output with the model on each falling edge
  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      chk("R7 cardState model", int'(cardState), mState);
      chk("R10 csn model", int'(csn), mCsn);
      chk("R10 ldn model", int'(ldn), mLdn);
      chk("R3 readPortAddr model", int'(readPortAddr), mPort);
      chk("R4 devReset model", int'(devReset), int'(mDev));
      chk("R9 rdData model", int'(rdData), mRead());
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic setIdx(input logic [7:0] i);
    addrWe = 1'b1; wrData = i; tick(); addrWe = 1'b0;
  endtask

  task automatic wrReg(input logic [7:0] i, input logic [7:0] d);
    setIdx(i); dataWe = 1'b1; wrData = d; tick(); dataWe = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] i, output int v);
    setIdx(i); dataRe = 1'b1; v = int'(rdData); tick(); dataRe = 1'b0;
  endtask

  task automatic key();
    keyOk = 1'b1; tick(); keyOk = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1; rstN = 1'b1; cmpOn = 1'b1;
    // R1 reset state
    chk("R1 state", int'(cardState), 0);
    chk("R1 csn", int'(csn), 0);
    chk("R1 ldn", int'(ldn), 0);
    chk("R1 port", int'(readPortAddr), 0);
    chk("R1 devReset", int'(devReset), 0);

    // R2 writes ignored while locked, then unlock
    wrReg(8'h00, 8'h55);
    wrReg(8'h02, 8'h07);
    chk("R2 locked write ignored", int'(readPortAddr), 0);
    chk("R2 locked devReset", int'(devReset), 0);
    key();
    chk("R2 key to sleep", int'(cardState), 1);

    // R3 read port set
    wrReg(8'h00, 8'hA7);
    chk("R3 port", int'(readPortAddr), 'h29C);
    rdReg(8'h00, v);
    chk("R11 read outside config", v, 0);

    // R7 wake mismatch then zero wake
    wrReg(8'h03, 8'h04);
    chk("R7 mismatch stays sleep", int'(cardState), 1);
    wrReg(8'h03, 8'h00);
    chk("R7 zero wake to isolation", int'(cardState), 2);
    wrReg(8'h07, 8'h03);
    chk("R10 ldn ignored in isolation", int'(ldn), 0);
    wrReg(8'h06, 8'h05);
    chk("R10 csn set in isolation", int'(csn), 5);

    // R5 back to locked, csn kept
    wrReg(8'h02, 8'h02);
    chk("R5 lock", int'(cardState), 0);
    chk("R5 csn kept", int'(csn), 5);
    key();
    wrReg(8'h03, 8'h05);
    chk("R7 csn wake to config", int'(cardState), 3);

    rdReg(8'h06, v); chk("R10 csn readback", v, 5);
    wrReg(8'h07, 8'h03);
    rdReg(8'h07, v); chk("R10 ldn readback", v, 3);

    // R9 resource stream
    rdReg(8'h05, v); chk("R9 status ready", v, 1);
    setIdx(8'h04);
    for (int k = 0; k < LEN; k++) begin
      chk("R9 resource byte", int'(rdData), resByte(k));
      dataRe = 1'b1; tick(); dataRe = 1'b0;
      chk("R9 not ready after read", int'(rdData), 0);
      tick();
    end
    chk("R9 exhausted data", int'(rdData), 0);
    rdReg(8'h05, v); chk("R9 exhausted status", v, 0);

    // R8 wake rewinds the stream, even on the busy cycle
    wrReg(8'h03, 8'h09);
    rdReg(8'h05, v); chk("R8 ready after rewind", v, 1);
    setIdx(8'h04);
    chk("R8 first byte again", int'(rdData), resByte(0));
    dataRe = 1'b1; addrWe = 1'b1; wrData = 8'h03; tick();
    dataRe = 1'b0; addrWe = 1'b0;
    dataWe = 1'b1; wrData = 8'h11; tick(); dataWe = 1'b0;
    rdReg(8'h04, v); chk("R8 rewind on busy cycle", v, resByte(0));

    // R4/R6 control bit 0 alone, readback zero
    wrReg(8'h02, 8'h01);
    chk("R4 devReset pulse", int'(devReset), 1);
    chk("R4 state kept", int'(cardState), 3);
    chk("R4 csn kept", int'(csn), 5);
    tick();
    chk("R4 single cycle", int'(devReset), 0);
    rdReg(8'h02, v); chk("R6 control reads zero", v, 0);

    // R4/R5/R6 all three bits in one write
    wrReg(8'h02, 8'h07);
    chk("R6 csn cleared", int'(csn), 0);
    chk("R5 locked", int'(cardState), 0);
    chk("R5 ldn kept", int'(ldn), 3);
    chk("R4 combined pulse", int'(devReset), 1);
    tick();
    key();
    wrReg(8'h02, 8'h04);
    chk("R6 clear in sleep", int'(csn), 0);
    chk("R6 sleep kept", int'(cardState), 1);
    rdReg(8'h05, v); chk("R11 status outside config", v, 0);
    tick();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule